// File: doc/BRIEF.md
# Tearing-Effect Transfer Start Controller

This block decides, for each virtual channel of a command-mode display link, the clock cycle in which a frame transfer is launched. A channel can be started in three ways. Software can start it directly. When the channel is armed, it can instead wait for a tearing-effect trigger message that the panel sent back over the link, or for a qualified event on one of the external tearing-effect input pins. Each channel raises a one-cycle start strobe, stays busy until the transfer logic reports completion, and then clears its own start and arm bits.

Each external pin feeds a qualifier that measures the high time of every pulse in clock cycles. A pulse is classed as vertical when it is long enough, and as horizontal when it is shorter than that but still above a smaller threshold. Pulses below both thresholds are dropped. Per pin, a mode bit selects the event that counts: every vertical pulse, or the N-th horizontal pulse. Any number of channels may listen to one pin. Pin inputs and link trigger strobes are expected to be already synchronous to the clock.

Top module: `te_start_ctrl`

## Requirements
- R1: After reset, start_pulse, start_bit, trig_en, busy and trig_irq are all 0.
- R2: If sw_start is high for a channel whose trig_en, start_bit and busy are all 0, then in the next cycle start_pulse is high for one cycle, and start_bit and busy are set.
- R3: sw_start has no effect while the channel's trig_en, start_bit or busy is set.
- R4: With trig_en=1 and line_sel=0, a link_trig on an idle channel gives start_pulse in the next cycle. Pin events do not start that channel.
- R5: With trig_en=1 and line_sel=1, an event on the pin chosen by pin_sel (value k selects te_pin[k]) starts an idle channel in the next cycle. link_trig does not start it.
- R6: A pulse's width is the number of rising clock edges at which te_pin was sampled high. It is vertical if width >= vs_width, horizontal if hs_width <= width < vs_width, and ignored otherwise. A pulse is judged in the cycle in which the pin is first sampled low, so a start caused by it appears in the following cycle.
- R7: With count_mode=0 for a pin, every vertical pulse is an event and horizontal pulses are not.
- R8: With count_mode=1 for a pin, an event occurs on the hs_num-th horizontal pulse counted since the last such event. A vertical pulse restarts the count. hs_num=0 behaves as 1.
- R9: xfer_done on a busy channel clears busy, start_bit and trig_en in the next cycle. xfer_done on an idle channel has no effect.
- R10: A busy channel never raises start_pulse. Triggers that arrive during a transfer are dropped and are not queued.
- R11: trig_irq pulses in the cycle after each link_trig of the channel or each event on the channel's selected pin, whatever the channel's mode.
- R12: en_set sets trig_en only when busy and start_bit are 0 and sw_start is low in the same cycle.
- R13: One pin event starts, in the same cycle, every armed idle channel that is set to pin mode and selects that pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_start | input | NUM_VC | Software start request per channel (one-cycle strobe) |
| en_set | input | NUM_VC | Arm request per channel (one-cycle strobe) |
| line_sel | input | NUM_VC | Per channel: 0 waits for link trigger, 1 waits for pin event |
| pin_sel | input | NUM_VC*PSEL_W | Per channel index of the tearing-effect pin it listens to |
| link_trig | input | NUM_VC | Trigger message received for channel (one-cycle strobe) |
| xfer_done | input | NUM_VC | Transfer finished on channel (one-cycle strobe) |
| te_pin | input | NUM_PINS | External tearing-effect inputs, already synchronous |
| vs_width | input | NUM_PINS*WID_W | Per pin minimum high width of a vertical pulse |
| hs_width | input | NUM_PINS*WID_W | Per pin minimum high width of a horizontal pulse |
| hs_num | input | NUM_PINS*HCNT_W | Per pin horizontal pulses per event in count mode |
| count_mode | input | NUM_PINS | Per pin: 0 vertical event, 1 counted horizontal event |
| start_pulse | output | NUM_VC | One-cycle transfer start strobe per channel |
| start_bit | output | NUM_VC | Software start bit, cleared on completion |
| trig_en | output | NUM_VC | Arm bit, cleared on completion |
| busy | output | NUM_VC | Transfer in progress |
| trig_irq | output | NUM_VC | One-cycle trigger interrupt pulse per channel |

## Verification
Two functions can meet in one cycle: the completion of a running transfer, and a fresh trigger or software start for the same channel. The bench forces this case by driving xfer_done together with link_trig, a pin falling edge or sw_start. It then expects busy to drop without a new start_pulse, because the trigger was seen while the channel was still busy, and trig_irq still to pulse. A second case is sw_start together with en_set on an idle channel. There the manual start must win and trig_en must stay clear. The random phases hit both cases often, and a cycle-accurate reference model written from the requirements judges every cycle.

// File: rtl/te_pkg.sv
`timescale 1ns/1ps
package te_pkg;

  typedef enum logic [1:0] {
    PK_NONE  = 2'd0,
    PK_HORIZ = 2'd1,
    PK_VERT  = 2'd2
  } pulse_kind_e;

  // Class a completed high pulse by its width in cycles.
  function automatic pulse_kind_e classify_width(input int unsigned width,
                                                 input int unsigned vert_min,
                                                 input int unsigned horiz_min);
    if (width >= vert_min)       return PK_VERT;
    else if (width >= horiz_min) return PK_HORIZ;
    else                         return PK_NONE;
  endfunction

  // True when the pulse being counted completes the programmed group.
  function automatic logic hcount_hit(input int unsigned seen,
                                      input int unsigned target);
    int unsigned eff;
    eff = (target == 0) ? 1 : target;
    return (seen + 1) >= eff;
  endfunction

endpackage

// File: rtl/te_pin_qual.sv
`timescale 1ns/1ps
module te_pin_qual
  import te_pkg::*;
#(
  parameter int WID_W  = 8,
  parameter int HCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              te_in,
  input  logic [WID_W-1:0]  vs_w,
  input  logic [WID_W-1:0]  hs_w,
  input  logic [HCNT_W-1:0] hs_num,
  input  logic              count_mode,
  output logic              pin_evt
);

  localparam logic [WID_W-1:0] WID_MAX = {WID_W{1'b1}};

  logic              prev_q;
  logic [WID_W-1:0]  hi_q;
  logic [HCNT_W-1:0] hc_q;
  logic              fall;
  logic              group_hit;
  pulse_kind_e       kind;

  assign fall = prev_q & ~te_in;

  always_comb begin
    kind      = classify_width(32'(hi_q), 32'(vs_w), 32'(hs_w));
    group_hit = hcount_hit(32'(hc_q), 32'(hs_num));
  end

  assign pin_evt = fall & (count_mode ? ((kind == PK_HORIZ) & group_hit)
                                      : (kind == PK_VERT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hi_q   <= '0;
      hc_q   <= '0;
    end else begin
      prev_q <= te_in;
      if (te_in) hi_q <= (hi_q == WID_MAX) ? hi_q : hi_q + 1'b1;
      else       hi_q <= '0;
      if (!count_mode) begin
        hc_q <= '0;
      end else if (fall) begin
        if (kind == PK_VERT)       hc_q <= '0;
        else if (kind == PK_HORIZ) hc_q <= group_hit ? '0 : hc_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/te_chan_ctrl.sv
`timescale 1ns/1ps
module te_chan_ctrl #(
  parameter int NUM_PINS = 2,
  parameter int PSEL_W   = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_start,
  input  logic                en_set,
  input  logic                line_sel,
  input  logic [PSEL_W-1:0]   pin_sel,
  input  logic                link_trig,
  input  logic                xfer_done,
  input  logic [NUM_PINS-1:0] pin_evt,
  output logic                start_pulse,
  output logic                start_bit,
  output logic                trig_en,
  output logic                busy,
  output logic                trig_irq
);

  logic pin_hit;
  logic arm_hit;
  logic man_hit;
  logic go;

  assign pin_hit = (32'(pin_sel) < NUM_PINS) ? pin_evt[pin_sel] : 1'b0;
  assign arm_hit = trig_en & ~busy & (line_sel ? pin_hit : link_trig);
  assign man_hit = sw_start & ~trig_en & ~start_bit & ~busy;
  assign go      = arm_hit | man_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pulse <= 1'b0;
      start_bit   <= 1'b0;
      trig_en     <= 1'b0;
      busy        <= 1'b0;
      trig_irq    <= 1'b0;
    end else begin
      start_pulse <= go;
      trig_irq    <= link_trig | pin_hit;
      if (busy & xfer_done) begin
        busy      <= 1'b0;
        start_bit <= 1'b0;
        trig_en   <= 1'b0;
      end else begin
        if (go)      busy      <= 1'b1;
        if (man_hit) start_bit <= 1'b1;
        if (en_set & ~sw_start & ~busy & ~start_bit) trig_en <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/te_start_ctrl.sv
`timescale 1ns/1ps
module te_start_ctrl #(
  parameter int NUM_VC   = 4,
  parameter int NUM_PINS = 2,
  parameter int WID_W    = 8,
  parameter int HCNT_W   = 4,
  parameter int PSEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_VC-1:0]          sw_start,
  input  logic [NUM_VC-1:0]          en_set,
  input  logic [NUM_VC-1:0]          line_sel,
  input  logic [NUM_VC*PSEL_W-1:0]   pin_sel,
  input  logic [NUM_VC-1:0]          link_trig,
  input  logic [NUM_VC-1:0]          xfer_done,
  input  logic [NUM_PINS-1:0]        te_pin,
  input  logic [NUM_PINS*WID_W-1:0]  vs_width,
  input  logic [NUM_PINS*WID_W-1:0]  hs_width,
  input  logic [NUM_PINS*HCNT_W-1:0] hs_num,
  input  logic [NUM_PINS-1:0]        count_mode,
  output logic [NUM_VC-1:0]          start_pulse,
  output logic [NUM_VC-1:0]          start_bit,
  output logic [NUM_VC-1:0]          trig_en,
  output logic [NUM_VC-1:0]          busy,
  output logic [NUM_VC-1:0]          trig_irq
);

  // Qualified event of each pin, shared by all channels.
  logic [NUM_PINS-1:0] pin_evt;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    te_pin_qual #(.WID_W(WID_W), .HCNT_W(HCNT_W)) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .te_in      (te_pin[p]),
      .vs_w       (vs_width[p*WID_W +: WID_W]),
      .hs_w       (hs_width[p*WID_W +: WID_W]),
      .hs_num     (hs_num[p*HCNT_W +: HCNT_W]),
      .count_mode (count_mode[p]),
      .pin_evt    (pin_evt[p])
    );
  end

  for (genvar c = 0; c < NUM_VC; c++) begin : g_chan
    te_chan_ctrl #(.NUM_PINS(NUM_PINS), .PSEL_W(PSEL_W)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .sw_start    (sw_start[c]),
      .en_set      (en_set[c]),
      .line_sel    (line_sel[c]),
      .pin_sel     (pin_sel[c*PSEL_W +: PSEL_W]),
      .link_trig   (link_trig[c]),
      .xfer_done   (xfer_done[c]),
      .pin_evt     (pin_evt),
      .start_pulse (start_pulse[c]),
      .start_bit   (start_bit[c]),
      .trig_en     (trig_en[c]),
      .busy        (busy[c]),
      .trig_irq    (trig_irq[c])
    );
  end

endmodule

// File: rtl/te_start_ctrl_chk.sv
`timescale 1ns/1ps
module te_start_ctrl_chk #(
  parameter int NUM_VC   = 4,
  parameter int NUM_PINS = 2,
  parameter int PSEL_W   = 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_VC-1:0]        sw_start,
  input logic [NUM_VC-1:0]        line_sel,
  input logic [NUM_VC*PSEL_W-1:0] pin_sel,
  input logic [NUM_VC-1:0]        link_trig,
  input logic [NUM_VC-1:0]        xfer_done,
  input logic [NUM_PINS-1:0]      pin_evt,
  input logic [NUM_VC-1:0]        start_pulse,
  input logic [NUM_VC-1:0]        start_bit,
  input logic [NUM_VC-1:0]        trig_en,
  input logic [NUM_VC-1:0]        busy,
  input logic [NUM_VC-1:0]        trig_irq
);

  for (genvar c = 0; c < NUM_VC; c++) begin : g_c
    logic [PSEL_W-1:0] ps;
    assign ps = pin_sel[c*PSEL_W +: PSEL_W];

    assert_manual_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_start[c] && !trig_en[c] && !start_bit[c] && !busy[c])
      |=> (start_pulse[c] && start_bit[c] && busy[c]));

    assert_sw_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_start[c] && trig_en[c]) |=> !start_bit[c]);

    assert_link_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_en[c] && !line_sel[c] && !busy[c] && link_trig[c]) |=> start_pulse[c]);

    assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[c] && xfer_done[c]) |=> (!busy[c] && !start_bit[c] && !trig_en[c]));

    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse[c] |-> (busy[c] && !$past(busy[c])));

    assert_irq_link_R11: assert property (@(posedge clk) disable iff (!rst_n)
      link_trig[c] |=> trig_irq[c]);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_p
      // R13: every listening channel reacts to the same pin event
      assert_pin_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en[c] && line_sel[c] && !busy[c] && (ps == PSEL_W'(p)) && pin_evt[p])
        |=> start_pulse[c]);
    end
  end

endmodule

bind te_start_ctrl te_start_ctrl_chk #(
  .NUM_VC(NUM_VC), .NUM_PINS(NUM_PINS), .PSEL_W(PSEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .line_sel(line_sel),
  .pin_sel(pin_sel), .link_trig(link_trig), .xfer_done(xfer_done),
  .pin_evt(pin_evt), .start_pulse(start_pulse), .start_bit(start_bit),
  .trig_en(trig_en), .busy(busy), .trig_irq(trig_irq)
);

// File: tb/tb_te_start_ctrl.sv
`timescale 1ns/1ps
module tb_te_start_ctrl;

  localparam int NV = 4;
  localparam int NP = 2;
  localparam int WW = 8;
  localparam int HW = 4;
  localparam int PW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NV-1:0]    sw_start = '0, en_set = '0, line_sel = '0, link_trig = '0, xfer_done = '0;
  logic [NV*PW-1:0] pin_sel = '0;
  logic [NP-1:0]    te_pin = '0, count_mode = '0;
  logic [NP*WW-1:0] vs_width = '0, hs_width = '0;
  logic [NP*HW-1:0] hs_num = '0;
  logic [NV-1:0]    start_pulse, start_bit, trig_en, busy, trig_irq;

  te_start_ctrl #(.NUM_VC(NV), .NUM_PINS(NP), .WID_W(WW), .HCNT_W(HW)) dut (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .en_set(en_set),
    .line_sel(line_sel), .pin_sel(pin_sel), .link_trig(link_trig),
    .xfer_done(xfer_done), .te_pin(te_pin), .vs_width(vs_width),
    .hs_width(hs_width), .hs_num(hs_num), .count_mode(count_mode),
    .start_pulse(start_pulse), .start_bit(start_bit), .trig_en(trig_en),
    .busy(busy), .trig_irq(trig_irq)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;
  string cur_req = "R1";

  // reference state
  bit [NV-1:0] m_sp, m_sb, m_te, m_busy, m_irq;
  int m_hi[NP];
  bit m_prev[NP];
  int m_hc[NP];

  task automatic check_vec(input string req, input string what,
                           input logic [NV-1:0] act, input logic [NV-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_bit(input string req, input string what,
                           input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // 0 none, 1 horizontal, 2 vertical (R6)
  function automatic int width_class(int w, int vmin, int hmin);
    if (w >= vmin) return 2;
    if (w >= hmin) return 1;
    return 0;
  endfunction

  task automatic model_reset();
    m_sp = '0; m_sb = '0; m_te = '0; m_busy = '0; m_irq = '0;
    for (int p = 0; p < NP; p++) begin m_hi[p] = 0; m_prev[p] = 0; m_hc[p] = 0; end
  endtask

  task automatic model_step();
    bit [NP-1:0] ev;
    for (int p = 0; p < NP; p++) begin
      int vmin, hmin, grp, k;
      bit falling, enough;
      vmin = int'(vs_width[p*WW +: WW]);
      hmin = int'(hs_width[p*WW +: WW]);
      grp  = int'(hs_num[p*HW +: HW]);
      if (grp == 0) grp = 1;
      falling = m_prev[p] && !te_pin[p];
      k = width_class(m_hi[p], vmin, hmin);
      enough = (m_hc[p] + 1) >= grp;
      ev[p] = falling && (count_mode[p] ? (k == 1 && enough) : (k == 2));
      if (!count_mode[p]) m_hc[p] = 0;
      else if (falling && k == 2) m_hc[p] = 0;
      else if (falling && k == 1) m_hc[p] = enough ? 0 : m_hc[p] + 1;
      m_hi[p] = te_pin[p] ? ((m_hi[p] >= 255) ? 255 : m_hi[p] + 1) : 0;
      m_prev[p] = te_pin[p];
    end
    for (int c = 0; c < NV; c++) begin
      bit phit, arm, man;
      phit = ev[pin_sel[c*PW +: PW]];
      arm = m_te[c] && !m_busy[c] && (line_sel[c] ? phit : link_trig[c]);
      man = sw_start[c] && !m_te[c] && !m_sb[c] && !m_busy[c];
      m_sp[c]  = arm || man;
      m_irq[c] = link_trig[c] || phit;
      if (m_busy[c] && xfer_done[c]) begin
        m_busy[c] = 0; m_sb[c] = 0; m_te[c] = 0;
      end else begin
        if (en_set[c] && !sw_start[c] && !m_busy[c] && !m_sb[c]) m_te[c] = 1;
        if (man) m_sb[c] = 1;
        if (arm || man) m_busy[c] = 1;
      end
    end
  endtask

  task automatic compare_all();
    check_vec(cur_req, "start_pulse (R2 R4 R5 R10)", start_pulse, m_sp);
    check_vec(cur_req, "start_bit (R2 R3)", start_bit, m_sb);
    check_vec(cur_req, "trig_en (R12 R9)", trig_en, m_te);
    check_vec(cur_req, "busy (R9 R10)", busy, m_busy);
    check_vec(cur_req, "trig_irq (R11)", trig_irq, m_irq);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic clear_strobes();
    sw_start = '0; en_set = '0; link_trig = '0; xfer_done = '0;
  endtask

  task automatic te_pulse(input int p, input int w);
    te_pin[p] = 1'b1;
    repeat (w) tick();
    te_pin[p] = 1'b0;
    tick();
  endtask

  initial begin
    #(200000 * 8);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check_vec("R1", "start_pulse", start_pulse, '0);
    check_vec("R1", "start_bit", start_bit, '0);
    check_vec("R1", "trig_en", trig_en, '0);
    check_vec("R1", "busy", busy, '0);
    check_vec("R1", "trig_irq", trig_irq, '0);
    rst_n = 1'b1;
    vs_width = {8'd8, 8'd8};
    hs_width = {8'd3, 8'd3};
    tick();

    // R2 manual start
    cur_req = "R2";
    sw_start[0] = 1'b1; tick(); clear_strobes();
    check_bit("R2", "start_pulse[0]", start_pulse[0], 1'b1);
    check_bit("R2", "start_bit[0]", start_bit[0], 1'b1);
    tick();
    check_bit("R2", "start_pulse[0] one cycle", start_pulse[0], 1'b0);

    // R3 / R10 start while busy
    cur_req = "R3";
    sw_start[0] = 1'b1; tick(); clear_strobes();
    check_bit("R3", "no restart while busy", start_pulse[0], 1'b0);

    // R9 done clears; done on idle channel ignored
    cur_req = "R9";
    xfer_done[0] = 1'b1; xfer_done[3] = 1'b1; tick(); clear_strobes();
    check_bit("R9", "busy[0] cleared", busy[0], 1'b0);
    check_bit("R9", "start_bit[0] cleared", start_bit[0], 1'b0);
    check_bit("R9", "idle ch3 unchanged", busy[3] | start_bit[3] | trig_en[3], 1'b0);

    // R12 arm, then R3 sw start ignored when armed
    cur_req = "R12";
    en_set[1] = 1'b1; tick(); clear_strobes();
    check_bit("R12", "trig_en[1] set", trig_en[1], 1'b1);
    cur_req = "R3";
    sw_start[1] = 1'b1; tick(); clear_strobes();
    check_bit("R3", "armed ignores sw_start", start_pulse[1] | start_bit[1], 1'b0);
    // R12 sw_start and en_set together: manual wins
    cur_req = "R12";
    sw_start[2] = 1'b1; en_set[2] = 1'b1; tick(); clear_strobes();
    check_bit("R12", "manual wins trig_en[2]", trig_en[2], 1'b0);
    check_bit("R12", "manual wins start_pulse[2]", start_pulse[2], 1'b1);
    xfer_done[2] = 1'b1; tick(); clear_strobes();

    // R4 link mode: pin event does not start, link trigger does
    cur_req = "R4";
    te_pulse(0, 9);
    check_bit("R4", "pin ignored in link mode", start_pulse[1], 1'b0);
    link_trig[1] = 1'b1; tick(); clear_strobes();
    check_bit("R4", "link start", start_pulse[1], 1'b1);
    // R10 and R11: trigger while busy dropped, irq still raised
    cur_req = "R10";
    link_trig[1] = 1'b1; xfer_done[1] = 1'b1; tick(); clear_strobes();
    check_bit("R10", "no start on done+trig", start_pulse[1], 1'b0);
    check_bit("R11", "irq on dropped trig", trig_irq[1], 1'b1);
    check_bit("R9", "trig_en[1] cleared", trig_en[1], 1'b0);

    // R5 R6 R7 R13: ch2, ch3 listen to pin 1, vertical mode
    cur_req = "R5";
    line_sel = 4'b1100; pin_sel = 4'b1100;
    en_set = 4'b1100; tick(); clear_strobes();
    link_trig[2] = 1'b1; tick(); clear_strobes();
    check_bit("R5", "link ignored in pin mode", start_pulse[2], 1'b0);
    cur_req = "R7";
    te_pulse(1, 7);
    check_bit("R7", "horizontal ignored in vertical mode", start_pulse[2], 1'b0);
    cur_req = "R6";
    te_pulse(1, 8);
    check_vec("R13", "both listeners start", start_pulse, 4'b1100);
    xfer_done = 4'b1100; tick(); clear_strobes();

    // R8 counted horizontal mode, N=3
    cur_req = "R8";
    count_mode[1] = 1'b1; hs_num[HW +: HW] = 4'd3;
    en_set[2] = 1'b1; tick(); clear_strobes();
    te_pulse(1, 3);
    check_bit("R8", "first horizontal", start_pulse[2], 1'b0);
    te_pulse(1, 2);
    check_bit("R6", "short pulse ignored", trig_irq[2], 1'b0);
    te_pulse(1, 4);
    check_bit("R8", "second horizontal", start_pulse[2], 1'b0);
    te_pulse(1, 3);
    check_bit("R8", "third horizontal starts", start_pulse[2], 1'b1);
    xfer_done[2] = 1'b1; tick(); clear_strobes();

    // constrained random phases judged by the model
    cur_req = "R11";
    for (int ph = 0; ph < 24; ph++) begin
      int run[NP];
      for (int p = 0; p < NP; p++) begin
        vs_width[p*WW +: WW] = WW'($urandom_range(9, 5));
        hs_width[p*WW +: WW] = WW'($urandom_range(4, 2));
        hs_num[p*HW +: HW]   = HW'($urandom_range(3, 0));
        count_mode[p]        = 1'($urandom_range(1, 0));
        run[p] = 0;
      end
      line_sel = NV'($urandom);
      pin_sel  = (NV*PW)'($urandom);
      for (int cy = 0; cy < 120; cy++) begin
        for (int c = 0; c < NV; c++) begin
          sw_start[c]  = ($urandom_range(99, 0) < 6);
          en_set[c]    = ($urandom_range(99, 0) < 8);
          link_trig[c] = ($urandom_range(99, 0) < 6);
          xfer_done[c] = ($urandom_range(99, 0) < 10);
        end
        for (int p = 0; p < NP; p++) begin
          if (run[p] == 0) begin
            te_pin[p] = ~te_pin[p];
            run[p] = te_pin[p] ? $urandom_range(11, 1) : $urandom_range(5, 1);
          end
          run[p]--;
        end
        tick();
      end
      clear_strobes();
    end

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule